// File: doc/BRIEF.md
# PCI Interrupt Routing Mode Switch

This block sits between four active-low, level-sensitive PCI interrupt lines and the inputs of the interrupt controllers. It works in one of two routing modes. In legacy routing, which covers both the cascaded-PIC mode and the virtual-wire mode, each PCI line can be steered onto any of the 16 ISA IRQ outputs by its own steering register. In symmetric I/O mode that steering is switched off. The four PCI lines then appear on the I/O APIC inputs 16 to 19. Inputs 0 to 15 of the APIC carry the ISA IRQs and stay clear of PCI traffic.

The block can enter symmetric mode in two ways. Software can set a mode-control bit, which it may clear again. The block can also sense that the APIC is being set up: the first write that unmasks any redirection entry switches it to symmetric mode. That switch holds until reset and needs no further software action. All outputs come from registers, so a mode change never glitches either output set. A write moves the mode on the clock edge that takes it, and the outputs follow on the next edge.

Software maps ISA IRQ n to vector 32+n. With that mapping, a PCI line steered to IRQ k arrives as vector 32+k in legacy mode.

Top module: `pci_irq_router`

## Requirements
- R1: After reset all lines are disabled and the mode is legacy. `isaIrq` and `apicIn` are all zero, whatever the PCI inputs do.
- R2: A write to address n (0 to 3) programs PCI line n. `wrData[3:0]` selects the ISA IRQ and `wrData[7]` enables the line. In legacy mode, an enabled line whose `pciIntN` bit is low drives `isaIrq` at the selected bit high. The output changes on the first clock edge that samples the input.
- R3: A disabled line drives no ISA output, whatever its steering value.
- R4: When several enabled lines select the same ISA IRQ, that output is the OR of their asserted states. Steering works at both ends of the IRQ range, IRQ 0 and IRQ 15.
- R5: A write to address 4 with `wrData[0]`=1 selects symmetric mode, and `wrData[0]`=0 returns to legacy mode unless symmetric mode was latched as in R6. In symmetric mode `isaIrq` is all zero, and `apicIn[16+n]` is high exactly while `pciIntN[n]` is low.
- R6: A write to address 5 with `wrData[7]`=0 is an unmasking redirection-entry write. It latches symmetric mode until reset, and a later address-4 write of 0 does not undo it. The same write with `wrData[7]`=1 is a masking write and changes nothing.
- R7: `apicIn[15:0]` and `apicIn[23:20]` are always zero. In legacy mode all of `apicIn` is zero.
- R8: After a mode-changing write taken at clock edge E, the outputs still show the old mode after E. They show the new mode from edge E+1.
- R9: Writes to addresses 6 to 15 change neither the routing nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 8 | Register write data |
| pciIntN | input | 4 | PCI interrupt lines, active low |
| isaIrq | output | 16 | ISA IRQ requests to the PIC stage, active high |
| apicIn | output | 24 | I/O APIC input requests, active high |

## Verification
The embedded properties check on every cycle that the ISA outputs are quiet in symmetric mode. They also check that each APIC input 16 to 19 follows its PCI line one cycle later, and that the reserved APIC inputs and the whole APIC set stay zero in legacy mode. They confirm that an unmasking redirection write always leaves symmetric mode set. They confirm that the mode holds without a mode write, and that no ISA output rises when every line is disabled. The bench scenarios are needed for the rest: the exact IRQ picked by each steering value, the OR-combining of shared IRQs, the difference between a masking and an unmasking redirection write, the one-edge lag after a mode write, and the proof that writes to unused addresses leave the routing alone.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NUM_PCI       = 4;
  localparam int NUM_ISA       = 16;
  localparam int NUM_APIC      = 24;
  localparam int APIC_PCI_BASE = 16;
  localparam int SEL_W         = $clog2(NUM_ISA);
  localparam int ADDR_W        = 4;
  localparam int DATA_W        = 8;
  localparam int EN_BIT        = DATA_W - 1;

  localparam logic [ADDR_W-1:0] ADDR_MODE  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ADDR_REDIR = ADDR_W'(5);

  // Strobes from control to datapath
  typedef struct packed {
    logic                           symMode;
    logic [NUM_PCI-1:0]             lineEn;
    logic [NUM_PCI-1:0][SEL_W-1:0]  lineSel;
  } route_cfg_t;
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter bit HAS_MODE_BIT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output route_cfg_t        cfg
);
  logic [NUM_PCI-1:0]            lineEn;
  logic [NUM_PCI-1:0][SEL_W-1:0] lineSel;
  logic                          modeBit;
  logic                          autoSym;
  logic                          unmaskWr;
  logic                          modeWr;

  assign unmaskWr = wrEn && (wrAddr == ADDR_REDIR) && !wrData[EN_BIT];
  assign modeWr   = wrEn && (wrAddr == ADDR_MODE);

  // Steering registers, one per PCI line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineEn  <= '0;
      lineSel <= '0;
    end else if (wrEn) begin
      for (int n = 0; n < NUM_PCI; n++) begin
        if (wrAddr == ADDR_W'(n)) begin
          lineSel[n] <= wrData[SEL_W-1:0];
          lineEn[n]  <= wrData[EN_BIT];
        end
      end
    end
  end

  // Sensing of APIC programming: sticky until reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         autoSym <= 1'b0;
    else if (unmaskWr) autoSym <= 1'b1;
  end

  generate
    if (HAS_MODE_BIT) begin : g_modeBit
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       modeBit <= 1'b0;
        else if (modeWr) modeBit <= wrData[0];
      end
    end else begin : g_noModeBit
      assign modeBit = 1'b0;
    end
  endgenerate

  assign cfg.symMode = modeBit | autoSym;
  assign cfg.lineEn  = lineEn;
  assign cfg.lineSel = lineSel;

  // R6
  unmask_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    unmaskWr |=> cfg.symMode);

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.symMode && !modeWr) |=> cfg.symMode);
endmodule

// File: rtl/irq_route_path.sv
module irq_route_path
  import irq_route_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PCI-1:0]  pciIntN,
  input  route_cfg_t          cfg,
  output logic [NUM_ISA-1:0]  isaIrq,
  output logic [NUM_APIC-1:0] apicIn
);
  logic [NUM_ISA-1:0]  isaNext;
  logic [NUM_APIC-1:0] apicNext;

  always_comb begin
    isaNext  = '0;
    apicNext = '0;
    for (int n = 0; n < NUM_PCI; n++) begin
      if (cfg.symMode)
        apicNext[APIC_PCI_BASE + n] = !pciIntN[n];
      else if (cfg.lineEn[n] && !pciIntN[n])
        isaNext = isaNext | (NUM_ISA'(1) << cfg.lineSel[n]);
    end
  end

  // Registered outputs: no glitch across a mode change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isaIrq <= '0;
      apicIn <= '0;
    end else begin
      isaIrq <= isaNext;
      apicIn <= apicNext;
    end
  end

  // R5
  isa_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfg.symMode |=> (isaIrq == '0));

  // R7
  legacy_apic_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.symMode |=> (apicIn == '0));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (apicIn[APIC_PCI_BASE-1:0] == '0) &&
    (apicIn[NUM_APIC-1:APIC_PCI_BASE+NUM_PCI] == '0));

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.lineEn == '0) |=> (isaIrq == '0));

  generate
    for (genvar g = 0; g < NUM_PCI; g++) begin : g_follow
      // R5
      apic_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
        cfg.symMode |=> (apicIn[APIC_PCI_BASE + g] == !$past(pciIntN[g])));
    end
  endgenerate
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import irq_route_pkg::*;
#(
  parameter bit HAS_MODE_BIT = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PCI-1:0]  pciIntN,
  output logic [NUM_ISA-1:0]  isaIrq,
  output logic [NUM_APIC-1:0] apicIn
);
  route_cfg_t cfg;

  irq_route_ctrl #(.HAS_MODE_BIT(HAS_MODE_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cfg(cfg)
  );

  irq_route_path u_path (
    .clk(clk), .rstN(rstN), .pciIntN(pciIntN), .cfg(cfg),
    .isaIrq(isaIrq), .apicIn(apicIn)
  );
endmodule

// File: tb/pci_irq_router_bench.sv
module pci_irq_router_bench;
  import irq_route_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rstN;
  logic                wrEn;
  logic [ADDR_W-1:0]   wrAddr;
  logic [DATA_W-1:0]   wrData;
  logic [NUM_PCI-1:0]  pciIntN;
  logic [NUM_ISA-1:0]  isaIrq;
  logic [NUM_APIC-1:0] apicIn;

  pci_irq_router u_pci_irq_router (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pciIntN(pciIntN), .isaIrq(isaIrq), .apicIn(apicIn)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // Bench's own model of the programmed state
  logic [3:0] mSel [NUM_PCI];
  logic       mEn  [NUM_PCI];
  logic       mModeBit, mAuto;

  function automatic logic [15:0] expIsa();
    logic [15:0] v = '0;
    if (!(mModeBit || mAuto))
      for (int n = 0; n < NUM_PCI; n++)
        if (mEn[n] && !pciIntN[n]) v[mSel[n]] = 1'b1;
    return v;
  endfunction

  function automatic logic [23:0] expApic();
    logic [23:0] v = '0;
    if (mModeBit || mAuto)
      for (int n = 0; n < NUM_PCI; n++) v[16 + n] = !pciIntN[n];
    return v;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
    if (a < 4) begin mSel[a] = d[3:0]; mEn[a] = d[7]; end
    else if (a == 4) mModeBit = d[0];
    else if (a == 5 && !d[7]) mAuto = 1'b1;
  endtask

  task automatic checkBoth(string req);
    check(req, 32'(isaIrq), 32'(expIsa()));
    check(req, 32'(apicIn), 32'(expApic()));
  endtask

  task automatic t_reset();
    pciIntN = 4'b0000;
    tick(); tick();
    check("R1 isa after reset", 32'(isaIrq), 32'h0);
    check("R1 apic after reset", 32'(apicIn), 32'h0);
    pciIntN = 4'b1111;
    tick();
  endtask

  task automatic t_steer();
    wr(4'd0, 8'h85);
    pciIntN = 4'b1110; tick();
    check("R2 line0 to irq5", 32'(isaIrq), 32'h0020);
    pciIntN = 4'b1111; tick();
    check("R2 line0 released", 32'(isaIrq), 32'h0);
  endtask

  task automatic t_disabled();
    wr(4'd1, 8'h03);
    pciIntN = 4'b1101; tick();
    check("R3 disabled line", 32'(isaIrq), 32'h0);
    checkBoth("R3 model");
    pciIntN = 4'b1111; tick();
  endtask

  task automatic t_shared();
    wr(4'd1, 8'h8A);
    wr(4'd2, 8'h8A);
    wr(4'd3, 8'h8F);
    pciIntN = 4'b1101; tick(); check("R4 shared line1", 32'(isaIrq), 32'h0400);
    pciIntN = 4'b1011; tick(); check("R4 shared line2", 32'(isaIrq), 32'h0400);
    pciIntN = 4'b1001; tick(); check("R4 shared both", 32'(isaIrq), 32'h0400);
    pciIntN = 4'b0110; tick(); check("R4 irq15 and irq5", 32'(isaIrq), 32'h8020);
    wr(4'd3, 8'h80);
    pciIntN = 4'b0111; tick(); check("R4 irq0", 32'(isaIrq), 32'h0001);
    for (int p = 0; p < 16; p++) begin
      pciIntN = 4'(p); tick(); checkBoth("R4 pattern sweep");
    end
    pciIntN = 4'b1111; tick();
  endtask

  task automatic t_unused();
    wr(4'd7, 8'h81);
    wr(4'd12, 8'h01);
    pciIntN = 4'b1110; tick();
    check("R9 unused addr isa", 32'(isaIrq), 32'h0020);
    check("R9 unused addr apic", 32'(apicIn), 32'h0);
  endtask

  task automatic t_modeBit();
    // pciIntN[0] asserted, line0 -> irq5 in legacy
    wr(4'd4, 8'h01);
    check("R8 old mode isa", 32'(isaIrq), 32'h0020);
    check("R8 old mode apic", 32'(apicIn), 32'h0);
    tick();
    check("R5 sym isa quiet", 32'(isaIrq), 32'h0);
    check("R5 sym apic16", 32'(apicIn), 32'h010000);
    pciIntN = 4'b0000; tick();
    check("R7 sym all lines", 32'(apicIn), 32'h0F0000);
    pciIntN = 4'b1110;
    wr(4'd4, 8'h00);
    tick();
    check("R5 back to legacy isa", 32'(isaIrq), 32'h0020);
    check("R7 legacy apic zero", 32'(apicIn), 32'h0);
  endtask

  task automatic t_auto();
    wr(4'd5, 8'h83);
    tick();
    check("R6 masked write no effect", 32'(isaIrq), 32'h0020);
    checkBoth("R6 masked model");
    wr(4'd5, 8'h03);
    check("R8 auto old mode", 32'(isaIrq), 32'h0020);
    tick();
    check("R6 unmask sym isa", 32'(isaIrq), 32'h0);
    check("R6 unmask sym apic", 32'(apicIn), 32'h010000);
    wr(4'd4, 8'h00);
    tick(); tick();
    check("R6 sticky after mode clear", 32'(apicIn), 32'h010000);
    check("R6 sticky isa", 32'(isaIrq), 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int n = 0; n < NUM_PCI; n++) begin mSel[n] = '0; mEn[n] = 1'b0; end
    mModeBit = 1'b0; mAuto = 1'b0;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; pciIntN = 4'b1111;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    tick();
    t_reset();
    t_steer();
    t_disabled();
    t_shared();
    t_unused();
    t_modeBit();
    t_auto();
    finish_run();
  end
endmodule